// File: doc/BRIEF.md
# Privilege Mode Instruction Gate

This unit sits in the decode stage. Each cycle it takes three status-register bits, the class of the instruction being decoded and the index of the control register that the instruction targets. From the status bits it works out one of four privilege modes: two supervisor modes (interrupt service and kernel) and two unprivileged modes (user and superuser). It then decides whether the instruction may execute in that mode.

The result comes out one cycle later, registered, together with a two-bit mode tag. The tag records the mode in force when that instruction entered. Because the mode travels with every instruction, the status bits may change from one instruction to the next and nothing has to be flushed. A refused instruction raises a privilege fault in place of execution.

Superuser mode can reach a subset of control registers, chosen by a per-register mask input. The keyring register is always closed to both unprivileged modes. The status register can be read by unprivileged code, but user mode cannot write it.

Top module: `priv_gate`

## Requirements
- R1: The mode tag is 2'b11 (ISR) for MD=1,RB=1,BL=1; 2'b10 (kernel) for MD=1,RB=0,BL=0; 2'b01 (superuser) for MD=0,RB=1,BL=0; 2'b00 (user) for MD=0,RB=0,BL=0.
- R2: With MD=1, any setting in which RB or BL is set gives the ISR tag 2'b11.
- R3: With MD=0 and BL=1, the mode is user (2'b00) whatever RB holds.
- R4: In kernel and ISR modes every opcode class on every control-register index is legal.
- R5: In user and superuser modes an instruction of class privileged (op_class_i=2'b01) is refused.
- R6: In user and superuser modes any read (2'b10) or write (2'b11) of the keyring register (index 1) is refused, whatever the mask holds.
- R7: In user mode a read of the status register (index 0) is legal and a write to it is refused.
- R8: In user mode a read or write of any control register other than index 0 is refused, whatever the mask holds.
- R9: In superuser mode a control-register access to an index other than 0 and 1 is legal exactly when su_mask_i holds a 1 at that index; a status-register write follows mask bit 0, and a status-register read is always legal.
- R10: Plain instructions (op_class_i=2'b00) are legal in every mode.
- R11: Results appear on the cycle after valid_i is sampled, tagged with the mode of that instruction. Back-to-back instructions in different modes each get their own tag and verdict, and no cycle is lost.
- R12: fault_o is high exactly when valid_o is high and legal_o is low. When valid_o is low, legal_o, fault_o and mode_o are all low.
- R13: While rst_ni is low, valid_o, legal_o, fault_o and mode_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction enters decode this cycle |
| sr_md_i | input | 1 | Status bit: supervisor |
| sr_rb_i | input | 1 | Status bit: bank select |
| sr_bl_i | input | 1 | Status bit: block |
| op_class_i | input | 2 | 00 plain, 01 privileged, 10 control read, 11 control write |
| creg_idx_i | input | IDX_W (5) | Target control-register index |
| su_mask_i | input | NUM_CREG (32) | Registers that superuser mode may access |
| valid_o | output | 1 | Result valid |
| mode_o | output | 2 | Mode tag of the instruction |
| legal_o | output | 1 | Instruction may execute |
| fault_o | output | 1 | Privilege fault request |

## Verification
A change of mode and a gated access can land in the same cycle. The status bits switch on exactly the cycle in which a privileged or keyring access enters, while the previous instruction is still sitting in the output register. The bench provokes this with unbroken runs of instructions that alternate between user and kernel bits and between mask settings. At each falling edge it judges the tag and the verdict against the bits that were driven one cycle earlier. A one-cycle bubble in the run must show up as a quiet output rather than a repeat of the previous result.

// File: rtl/priv_gate_pkg.sv
package priv_gate_pkg;
  typedef enum logic [1:0] {
    MODE_USER   = 2'b00,
    MODE_SUPER  = 2'b01,
    MODE_KERNEL = 2'b10,
    MODE_ISR    = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    OP_PLAIN   = 2'b00,
    OP_PRIV    = 2'b01,
    OP_CREG_RD = 2'b10,
    OP_CREG_WR = 2'b11
  } op_e;

  typedef struct packed {
    logic md;
    logic rb;
    logic bl;
  } sr_bits_t;
endpackage

// File: rtl/priv_mode_decode.sv
module priv_mode_decode
  import priv_gate_pkg::*;
(
  input  sr_bits_t sr_i,
  output mode_e    mode_o
);
  always_comb begin
    if (sr_i.md) begin
      mode_o = (sr_i.rb || sr_i.bl) ? MODE_ISR : MODE_KERNEL;
    end else if (sr_i.bl) begin
      mode_o = MODE_USER;  // invalid combination collapses to user
    end else if (sr_i.rb) begin
      mode_o = MODE_SUPER;
    end else begin
      mode_o = MODE_USER;
    end
  end
endmodule

// File: rtl/priv_access_check.sv
module priv_access_check
  import priv_gate_pkg::*;
#(
  parameter int NUM_CREG = 32,
  parameter int IDX_W    = 5,
  parameter int SR_IDX   = 0,
  parameter int KEY_IDX  = 1
) (
  input  mode_e               mode_i,
  input  op_e                 op_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [NUM_CREG-1:0] su_mask_i,
  output logic                legal_o
);
  localparam int IDX_SPAN = 1 << IDX_W;
  localparam logic [IDX_W-1:0] SR_SEL  = IDX_W'(SR_IDX);
  localparam logic [IDX_W-1:0] KEY_SEL = IDX_W'(KEY_IDX);

  logic [IDX_SPAN-1:0] mask_ext;
  logic                mask_hit;
  logic                priv_mode;
  logic                is_wr;

  generate
    if (IDX_SPAN > NUM_CREG) begin : g_pad
      assign mask_ext = {{(IDX_SPAN-NUM_CREG){1'b0}}, su_mask_i};
    end else begin : g_exact
      assign mask_ext = su_mask_i;
    end
  endgenerate

  assign mask_hit  = mask_ext[idx_i];
  assign priv_mode = mode_i[1];
  assign is_wr     = (op_i == OP_CREG_WR);

  always_comb begin
    legal_o = 1'b1;
    if (!priv_mode) begin
      unique case (op_i)
        OP_PLAIN: legal_o = 1'b1;
        OP_PRIV:  legal_o = 1'b0;
        default: begin
          if (idx_i == KEY_SEL)                  legal_o = 1'b0;
          else if (idx_i == SR_SEL && !is_wr)    legal_o = 1'b1;
          else if (mode_i == MODE_SUPER)         legal_o = mask_hit;
          else                                   legal_o = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/priv_tag_stage.sv
module priv_tag_stage
  import priv_gate_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  mode_e mode_i,
  input  logic  legal_i,
  output logic  valid_o,
  output mode_e mode_o,
  output logic  legal_o,
  output logic  fault_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mode_o  <= MODE_USER;
      legal_o <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      mode_o  <= valid_i ? mode_i : MODE_USER;
      legal_o <= valid_i && legal_i;
      fault_o <= valid_i && !legal_i;
    end
  end

  p_verdict_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (legal_o != fault_o));
  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!legal_o && !fault_o && mode_o == MODE_USER));
endmodule

// File: rtl/priv_gate.sv
module priv_gate
  import priv_gate_pkg::*;
#(
  parameter int NUM_CREG = 32,
  parameter int SR_IDX   = 0,
  parameter int KEY_IDX  = 1,
  localparam int IDX_W   = $clog2(NUM_CREG)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                sr_md_i,
  input  logic                sr_rb_i,
  input  logic                sr_bl_i,
  input  logic [1:0]          op_class_i,
  input  logic [IDX_W-1:0]    creg_idx_i,
  input  logic [NUM_CREG-1:0] su_mask_i,
  output logic                valid_o,
  output logic [1:0]          mode_o,
  output logic                legal_o,
  output logic                fault_o
);
  sr_bits_t sr_bits;
  mode_e    cur_mode;
  mode_e    tag_mode;
  logic     cur_legal;

  assign sr_bits = '{md: sr_md_i, rb: sr_rb_i, bl: sr_bl_i};

  priv_mode_decode u_decode (
    .sr_i   (sr_bits),
    .mode_o (cur_mode)
  );

  priv_access_check #(
    .NUM_CREG (NUM_CREG),
    .IDX_W    (IDX_W),
    .SR_IDX   (SR_IDX),
    .KEY_IDX  (KEY_IDX)
  ) u_check (
    .mode_i    (cur_mode),
    .op_i      (op_e'(op_class_i)),
    .idx_i     (creg_idx_i),
    .su_mask_i (su_mask_i),
    .legal_o   (cur_legal)
  );

  priv_tag_stage u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .mode_i  (cur_mode),
    .legal_i (cur_legal),
    .valid_o (valid_o),
    .mode_o  (tag_mode),
    .legal_o (legal_o),
    .fault_o (fault_o)
  );

  assign mode_o = tag_mode;

  p_sup_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sr_md_i) |=> legal_o);
  p_unpriv_op_fault_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sr_md_i && op_class_i == 2'b01) |=> fault_o);
  p_key_refused_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sr_md_i && op_class_i[1] && creg_idx_i == IDX_W'(KEY_IDX)) |=> fault_o);
  p_bl_user_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sr_md_i && sr_bl_i) |=> (mode_o == 2'b00));
  p_tag_follows_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (valid_o && mode_o[1] == $past(sr_md_i)));
endmodule

// File: tb/priv_gate_bench.sv
module priv_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        md = 1'b0, rb = 1'b0, bl = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [4:0]  idx = '0;
  logic [31:0] mask = '0;
  logic        valid_o, legal_o, fault_o;
  logic [1:0]  mode_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  priv_gate u_priv_gate (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid),
    .sr_md_i(md), .sr_rb_i(rb), .sr_bl_i(bl),
    .op_class_i(op), .creg_idx_i(idx), .su_mask_i(mask),
    .valid_o(valid_o), .mode_o(mode_o), .legal_o(legal_o), .fault_o(fault_o)
  );

  task automatic check(string req, string what, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // issue one instruction at a falling edge, judge it at the next falling edge
  task automatic step(string req, logic m, logic r, logic b, logic [1:0] o,
                      logic [4:0] i, logic [31:0] k, logic [1:0] em, logic el);
    md = m; rb = r; bl = b; op = o; idx = i; mask = k; valid = 1'b1;
    @(negedge clk);
    check(req, "valid", int'(valid_o), 1);
    check(req, "mode", int'(mode_o), int'(em));
    check(req, "legal", int'(legal_o), int'(el));
    check("R12", "fault", int'(fault_o), int'(!el));
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R13", "valid", int'(valid_o), 0);
    check("R13", "legal", int'(legal_o), 0);
    check("R13", "fault", int'(fault_o), 0);
    check("R13", "mode", int'(mode_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_modes;
    step("R1", 1, 1, 1, 2'b00, 0, 0, 2'b11, 1);
    step("R1", 1, 0, 0, 2'b00, 0, 0, 2'b10, 1);
    step("R1", 0, 1, 0, 2'b00, 0, 0, 2'b01, 1);
    step("R1", 0, 0, 0, 2'b00, 0, 0, 2'b00, 1);
  endtask

  task automatic t_odd_bits;
    step("R2", 1, 1, 0, 2'b00, 0, 0, 2'b11, 1);
    step("R2", 1, 0, 1, 2'b01, 0, 0, 2'b11, 1);
    step("R3", 0, 0, 1, 2'b00, 0, 0, 2'b00, 1);
    // RB+BL with MD clear: user, so a masked register stays closed
    step("R3", 0, 1, 1, 2'b10, 5, 32'hffff_ffff, 2'b00, 0);
  endtask

  task automatic t_supervisor;
    step("R4", 1, 0, 0, 2'b01, 0, 0, 2'b10, 1);
    step("R4", 1, 1, 1, 2'b11, 1, 0, 2'b11, 1);
    step("R4", 1, 0, 0, 2'b11, 0, 0, 2'b10, 1);
    step("R4", 1, 0, 0, 2'b10, 31, 0, 2'b10, 1);
  endtask

  task automatic t_unpriv;
    step("R5", 0, 0, 0, 2'b01, 0, 32'hffff_ffff, 2'b00, 0);
    step("R5", 0, 1, 0, 2'b01, 0, 32'hffff_ffff, 2'b01, 0);
    step("R6", 0, 0, 0, 2'b10, 1, 32'hffff_ffff, 2'b00, 0);
    step("R6", 0, 1, 0, 2'b11, 1, 32'hffff_ffff, 2'b01, 0);
    step("R6", 0, 1, 0, 2'b10, 1, 32'hffff_ffff, 2'b01, 0);
    step("R7", 0, 0, 0, 2'b10, 0, 0, 2'b00, 1);
    step("R7", 0, 0, 0, 2'b11, 0, 32'hffff_ffff, 2'b00, 0);
    step("R8", 0, 0, 0, 2'b10, 5, 32'hffff_ffff, 2'b00, 0);
    step("R8", 0, 0, 0, 2'b11, 31, 32'hffff_ffff, 2'b00, 0);
    step("R10", 0, 0, 0, 2'b00, 1, 0, 2'b00, 1);
    step("R10", 0, 1, 0, 2'b00, 1, 0, 2'b01, 1);
  endtask

  task automatic t_superuser_mask;
    step("R9", 0, 1, 0, 2'b10, 5, 32'h0000_0020, 2'b01, 1);
    step("R9", 0, 1, 0, 2'b10, 5, 32'hffff_ffdf, 2'b01, 0);
    step("R9", 0, 1, 0, 2'b11, 31, 32'h8000_0000, 2'b01, 1);
    step("R9", 0, 1, 0, 2'b11, 0, 32'h0000_0001, 2'b01, 1);
    step("R9", 0, 1, 0, 2'b11, 0, 32'h0000_0000, 2'b01, 0);
    step("R9", 0, 1, 0, 2'b10, 0, 32'h0000_0000, 2'b01, 1);
  endtask

  task automatic t_back_to_back;
    step("R11", 0, 0, 0, 2'b01, 0, 0, 2'b00, 0);
    step("R11", 1, 0, 0, 2'b01, 0, 0, 2'b10, 1);
    step("R11", 0, 1, 0, 2'b01, 0, 0, 2'b01, 0);
    step("R11", 1, 1, 1, 2'b11, 1, 0, 2'b11, 1);
    step("R11", 0, 1, 0, 2'b11, 1, 0, 2'b01, 0);
    // bubble: no repeat of the previous verdict
    valid = 1'b0; md = 1'b1; op = 2'b01;
    @(negedge clk);
    check("R12", "bubble valid", int'(valid_o), 0);
    check("R12", "bubble legal", int'(legal_o), 0);
    check("R12", "bubble fault", int'(fault_o), 0);
    check("R12", "bubble mode", int'(mode_o), 0);
    step("R11", 0, 0, 0, 2'b01, 0, 0, 2'b00, 0);
    valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset;
    t_modes;
    t_odd_bits;
    t_supervisor;
    t_unpriv;
    t_superuser_mask;
    t_back_to_back;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule